// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is a synthesizable model of a synchronous burst static RAM. Address, chip selects, strobes, advance and write enables are all sampled on the rising clock edge. Each edge is sorted into one of five kinds of cycle: no operation, deselect, burst start, burst continue or burst suspend. A started burst is a read or a write.

A burst can be started by either of two address strobes. The host strobe is gated by the master enable and always starts a read. The controller strobe only counts when the host strobe is not active on the same edge, and it samples the write enables. Inside a burst, a four-beat address sequence steps through the low two address bits, in either wrapping linear or XOR (interleaved) order. Reads travel through two register stages. The read bus uses double-cycle deselect and is also gated by an asynchronous output enable.

The array size and lane width are parameters, so a small array can be used in simulation.

Top module: `burst_sram_ctrl`

## Requirements
- R1: A strobe edge that starts a cycle while chip select is false is a deselect. It starts no access, and later edges with both strobes high start nothing and keep `dq_oe` low. Chip select is true only when `ce_main_n`=0, `ce_hi`=1 and `ce_lo_n`=0.
- R2: When `ce_main_n`=1, a low `strobe_cpu_n` has no effect. If `strobe_ctl_n` is also high, an ongoing burst continues as if both strobes were high.
- R3: When `ce_main_n`=0 and both strobes are low on the same edge, the host strobe wins and the cycle is a read. The write enables do not alter the array.
- R4: A burst started by the host strobe is a read at the external address. Write enables and `adv_n` are ignored on that edge.
- R5: The write lane mask works as follows. If `wr_all_n`=0, every lane is written. If `wr_all_n`=1 and `wr_lane_en_n`=0, lane b is written when `lane_sel_n[b]`=0, where lane b is `wdata[8b+7:8b]`. If no lane is selected, the cycle is a read.
- R6: A read addressed on clock edge E drives its word on `rdata` with `dq_oe`=1 after edge E+1, and not after edge E alone.
- R7: On an edge that performs a write, `dq_oe` goes low after that edge whatever `oe_n` is, and `wdata` is stored on that same edge.
- R8: After a deselect command that follows a read, `dq_oe` stays high with the last read word for two edges, then goes low.
- R9: When `adv_n`=1 and both strobes are high during a burst, the access address does not change.
- R10: On a burst beat k (k = 0..3), the low two address bits are `start+k` modulo 4 when `linear_mode`=1, and `start^k` when `linear_mode`=0. The upper address bits stay fixed.
- R11: `oe_n`=1 forces `dq_oe` low at once. The read pipeline and `rdata` are left unchanged.
- R12: After reset, `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| ce_main_n | input | 1 | Master chip enable, active low; gates the host strobe |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_lo_n | input | 1 | Tertiary chip enable, active low |
| strobe_cpu_n | input | 1 | Host address strobe, active low |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low; writes every lane |
| wr_lane_en_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| linear_mode | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | External word address |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data from the output register |
| dq_oe | output | 1 | Read bus drive enable |

## Verification
The hardest sequences to set up are the ones that need several edges of live burst state. Examples are a write edge that lands while the read bus is already driven, and a deselect that arrives right after a read. Either one can hide the double-cycle hold or the drive kill.

The bench handles this by driving a suspended read until the bus is visibly driven. It then issues the write or deselect command, and samples `dq_oe` on each following edge.

A sweep over both burst orders and all four start offsets checks every beat address against its arithmetic value.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_DSEL  = 3'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_DS   = 2'd2
  } stage_e;
endpackage

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
  import sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             active,
  input  logic             ce_main_n,
  input  logic             ce_hi,
  input  logic             ce_lo_n,
  input  logic             strobe_cpu_n,
  input  logic             strobe_ctl_n,
  input  logic             adv_n,
  input  logic             wr_all_n,
  input  logic             wr_lane_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  output op_e              op,
  output logic             load,
  output logic             step,
  output logic [LANES-1:0] wmask
);
  // lane mask: global write overrides the individual lane selects
  function automatic logic [LANES-1:0] lane_mask(input logic all_n, input logic en_n,
                                                 input logic [LANES-1:0] sel_n);
    if (!all_n)     return '1;
    else if (!en_n) return ~sel_n;
    else            return '0;
  endfunction

  logic             cpu_go, ctl_go, chip_sel;
  logic [LANES-1:0] mask_now;

  always_comb begin
    cpu_go   = !strobe_cpu_n && !ce_main_n;
    ctl_go   = !strobe_ctl_n && (strobe_cpu_n || ce_main_n);
    chip_sel = !ce_main_n && ce_hi && !ce_lo_n;
    mask_now = lane_mask(wr_all_n, wr_lane_en_n, lane_sel_n);
    op       = OP_NONE;
    load     = 1'b0;
    step     = 1'b0;
    wmask    = '0;
    if (cpu_go || ctl_go) begin
      if (!chip_sel) begin
        op = OP_DSEL;
      end else begin
        load = 1'b1;
        if (ctl_go && (|mask_now)) begin
          op    = OP_WRITE;
          wmask = mask_now;
        end else begin
          op = OP_READ;
        end
      end
    end else if (active) begin
      step  = !adv_n;
      wmask = mask_now;
      op    = (|mask_now) ? OP_WRITE : OP_READ;
    end
  end
endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr #(
  parameter int ADDR_W = 8,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              linear_mode,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] acc_addr
);
  // beat order within the wrapping block
  function automatic logic [BEAT_W-1:0] beat_low(input logic [BEAT_W-1:0] start,
                                                 input logic [BEAT_W-1:0] idx,
                                                 input logic lin);
    return lin ? BEAT_W'(start + idx) : (start ^ idx);
  endfunction

  logic [ADDR_W-1:0] base_q, base_n;
  logic [BEAT_W-1:0] idx_q, idx_n;

  always_comb begin
    base_n   = load ? ext_addr : base_q;
    idx_n    = load ? '0 : (step ? BEAT_W'(idx_q + 1'b1) : idx_q);
    acc_addr = {base_n[ADDR_W-1:BEAT_W], beat_low(base_n[BEAT_W-1:0], idx_n, linear_mode)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
    end else begin
      base_q <= base_n;
      idx_q  <= idx_n;
    end
  end
endmodule

// File: rtl/sram_read_pipe.sv
module sram_read_pipe
  import sram_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic [DW-1:0] rd_word,
  output logic          drive,
  output logic [DW-1:0] dout
);
  stage_e s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= ST_IDLE;
      drive <= 1'b0;
      dout  <= '0;
    end else begin
      case (op)
        OP_READ: s1_q <= ST_RD;
        OP_DSEL: s1_q <= ST_DS;
        default: s1_q <= ST_IDLE;
      endcase
      // a write kills the drive; a deselect holds it one extra cycle
      if (op == OP_WRITE) drive <= 1'b0;
      else                drive <= (s1_q == ST_RD) || ((s1_q == ST_DS) && drive);
      if (s1_q == ST_RD) dout <= rd_word;
    end
  end
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_main_n,
  input  logic                    ce_hi,
  input  logic                    ce_lo_n,
  input  logic                    strobe_cpu_n,
  input  logic                    strobe_ctl_n,
  input  logic                    adv_n,
  input  logic                    wr_all_n,
  input  logic                    wr_lane_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    linear_mode,
  input  logic                    oe_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    dq_oe
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  op_e               op;
  logic              load, step, active_q, bus_drive;
  logic [LANES-1:0]  wmask;
  logic [ADDR_W-1:0] acc_addr, s1_addr;
  logic [DW-1:0]     rd_word;

  sram_cycle_decode #(.LANES(LANES)) u_dec (
    .active(active_q), .ce_main_n(ce_main_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
    .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .lane_sel_n(lane_sel_n),
    .op(op), .load(load), .step(step), .wmask(wmask)
  );

  sram_burst_addr #(.ADDR_W(ADDR_W), .BEAT_W(2)) u_burst (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .linear_mode(linear_mode),
    .ext_addr(addr), .acc_addr(acc_addr)
  );

  sram_read_pipe #(.DW(DW)) u_pipe (
    .clk(clk), .rst_n(rst_n), .op(op), .rd_word(rd_word), .drive(bus_drive), .dout(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      s1_addr  <= '0;
    end else begin
      if (op == OP_DSEL)  active_q <= 1'b0;
      else if (load)      active_q <= 1'b1;
      s1_addr <= acc_addr;
    end
  end

  // one storage array per byte lane
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (op == OP_WRITE && wmask[b]) lane_mem[acc_addr] <= wdata[b*LANE_W +: LANE_W];
    end
    assign rd_word[b*LANE_W +: LANE_W] = lane_mem[s1_addr];
  end

  assign dq_oe = bus_drive && !oe_n;

  a_r7_write_drops_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE) |=> !bus_drive);

  a_r6_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ) ##1 (op != OP_WRITE) |=> bus_drive);

  a_r8_double_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ) ##1 (op == OP_DSEL) ##1 (op != OP_WRITE) |-> bus_drive ##1 bus_drive);

  a_r9_suspend_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !load && !step && (op == OP_READ || op == OP_WRITE)) |-> (acc_addr == s1_addr));

  a_r10_block_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && step && !load) |-> (acc_addr[ADDR_W-1:2] == s1_addr[ADDR_W-1:2]));

  a_r2_main_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_main_n && strobe_ctl_n) |-> !load);
endmodule

// File: tb/sim_burst_sram_ctrl.sv
module sim_burst_sram_ctrl;
  localparam int AW = 6;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_main_n, ce_hi, ce_lo_n, strobe_cpu_n, strobe_ctl_n, adv_n;
  logic wr_all_n, wr_lane_en_n, linear_mode, oe_n;
  logic [NB-1:0] lane_sel_n;
  logic [AW-1:0] addr;
  logic [31:0]   wdata, rdata;
  logic          dq_oe;
  logic [31:0]   refm [64];
  int checks = 0;
  int fails  = 0;

  burst_sram_ctrl #(.ADDR_W(AW), .LANES(NB), .LANE_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_main_n(ce_main_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
    .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .lane_sel_n(lane_sel_n),
    .linear_mode(linear_mode), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .dq_oe(dq_oe)
  );

  always #10 clk = ~clk;

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce_main_n = 0; ce_hi = 1; ce_lo_n = 0;
    strobe_cpu_n = 1; strobe_ctl_n = 1; adv_n = 1;
    wr_all_n = 1; wr_lane_en_n = 1; lane_sel_n = '1;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic desel();
    idle(); strobe_ctl_n = 0; ce_hi = 0;
    tick(); idle(); tick(); tick(); tick();
  endtask

  task automatic cpu_begin(input logic [AW-1:0] a);
    idle(); strobe_cpu_n = 0; addr = a;
    tick(); idle();
  endtask

  function automatic logic [31:0] pat(input int a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  // read one word from a deselected state; R6 latency is checked on the way
  task automatic rd_single(input logic [AW-1:0] a, input string req);
    cpu_begin(a);
    check("R6 not yet driven", {31'd0, dq_oe}, 32'd1 ^ 32'd1);
    tick();
    check(req, {31'd0, dq_oe}, 32'd1);
    check(req, rdata, refm[a]);
    desel();
  endtask

  initial begin
    idle(); linear_mode = 1; oe_n = 0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R12 reset", {31'd0, dq_oe}, 32'd0);
    rst_n = 1;
    tick();

    // fill the array with global writes through the controller strobe
    for (int a = 0; a < 64; a++) begin
      idle(); strobe_ctl_n = 0; wr_all_n = 0; addr = AW'(a); wdata = pat(a);
      refm[a] = pat(a);
      tick();
    end
    idle();
    desel();

    // R1: deselect through each inactive enable, then idle edges stay quiet
    idle(); strobe_cpu_n = 0; ce_lo_n = 1; addr = 6'd3; tick();
    idle(); adv_n = 0;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R1 deselected by ce_lo_n", {31'd0, dq_oe}, 32'd0);
    end
    idle(); strobe_ctl_n = 0; ce_hi = 0; addr = 6'd4; tick();
    idle(); tick(); tick();
    check("R1 deselected by ce_hi", {31'd0, dq_oe}, 32'd0);

    // R10: burst order sweep
    for (int lin = 0; lin < 2; lin++) begin
      for (int s = 0; s < 4; s++) begin
        linear_mode = lin[0];
        cpu_begin(AW'(16 + s));
        for (int k = 1; k < 4; k++) begin
          adv_n = 0; tick();
          check("R10 beat data", rdata,
                refm[16 + (lin != 0 ? ((s + k - 1) & 3) : (s ^ (k - 1)))]);
        end
        adv_n = 1; tick();
        check("R10 last beat", rdata, refm[16 + (lin != 0 ? ((s + 3) & 3) : (s ^ 3))]);
        desel();
      end
    end
    linear_mode = 1;

    // R9: suspend holds the address
    cpu_begin(6'd41);
    tick(); check("R9 suspend beat", rdata, refm[41]);
    tick(); check("R9 suspend beat", rdata, refm[41]);
    adv_n = 0; tick(); check("R9 suspend beat", rdata, refm[41]);
    adv_n = 1; tick(); check("R9 after advance", rdata, refm[42]);
    desel();

    // R2: blocked host strobe while a burst is live
    cpu_begin(6'd32);
    adv_n = 0; ce_main_n = 1; strobe_cpu_n = 0; addr = 6'd50; tick();
    check("R2 first beat", rdata, refm[32]);
    idle(); adv_n = 0; tick();
    check("R2 burst continued", rdata, refm[33]);
    desel();

    // R3: both strobes low, host wins, no write
    idle(); strobe_cpu_n = 0; strobe_ctl_n = 0; wr_all_n = 0; addr = 6'd7;
    wdata = 32'hDEADBEEF; tick();
    idle(); tick();
    check("R3 host wins read", rdata, refm[7]);
    check("R3 driven", {31'd0, dq_oe}, 32'd1);
    desel();
    rd_single(6'd7, "R3 array unchanged");

    // R4: host start ignores write enables and advance
    idle(); strobe_cpu_n = 0; wr_all_n = 0; wr_lane_en_n = 0; lane_sel_n = '0; adv_n = 0;
    addr = 6'd9; wdata = 32'h12345678; tick();
    idle(); tick();
    check("R4 read at external address", rdata, refm[9]);
    desel();
    rd_single(6'd9, "R4 array unchanged");

    // R5: lane writes, global override, empty mask read
    idle(); strobe_ctl_n = 0; wr_lane_en_n = 0; lane_sel_n = 4'b1010; addr = 6'd40;
    wdata = 32'hCAFEF00D; tick();
    refm[40] = {refm[40][31:24], 8'hFE, refm[40][15:8], 8'h0D};
    idle(); desel();
    rd_single(6'd40, "R5 lanes 0 and 2");
    idle(); strobe_ctl_n = 0; wr_all_n = 0; wr_lane_en_n = 0; lane_sel_n = 4'b1110;
    addr = 6'd44; wdata = 32'h0BADCAFE; tick();
    refm[44] = 32'h0BADCAFE;
    idle(); desel();
    rd_single(6'd44, "R5 global overrides lanes");
    idle(); strobe_ctl_n = 0; wr_lane_en_n = 0; lane_sel_n = '1; addr = 6'd40;
    wdata = 32'h0; tick();
    idle(); tick();
    check("R5 empty mask is read", rdata, refm[40]);
    check("R5 empty mask driven", {31'd0, dq_oe}, 32'd1);
    desel();

    // R7: write edge inside a driven read burst
    cpu_begin(6'd12);
    tick();
    check("R7 driven before write", {31'd0, dq_oe}, 32'd1);
    wr_lane_en_n = 0; lane_sel_n = '0; wdata = 32'h600DD00D; tick();
    refm[12] = 32'h600DD00D;
    check("R7 drive dropped", {31'd0, dq_oe}, 32'd0);
    idle(); desel();
    rd_single(6'd12, "R7 data captured");

    // R8: double-cycle deselect
    cpu_begin(6'd13);
    tick();
    idle(); strobe_ctl_n = 0; ce_hi = 0; tick();
    check("R8 held edge 1", {31'd0, dq_oe}, 32'd1);
    check("R8 held data", rdata, refm[13]);
    idle(); tick();
    check("R8 held edge 2", {31'd0, dq_oe}, 32'd1);
    tick();
    check("R8 released", {31'd0, dq_oe}, 32'd0);
    tick();

    // R11: asynchronous output enable
    cpu_begin(6'd21);
    tick();
    oe_n = 1; #1;
    check("R11 oe high blocks", {31'd0, dq_oe}, 32'd0);
    tick();
    oe_n = 0; #1;
    check("R11 drive back", {31'd0, dq_oe}, 32'd1);
    check("R11 data intact", rdata, refm[21]);
    desel();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule